// File: doc/BRIEF.md
# Debug Authentication and Halt-Entry Controller

This block sits beside one processor core and decides what kind of debug access is allowed, then runs the handshake that brings the core into halting debug state. Two authentication enables set the permissions. One allows intrusive (invasive) debug. The other allows observation-only (non-invasive) debug. The intrusive enable also implies observation rights.

An external halt request is accepted only while intrusive debug is allowed. An accepted request raises a halt command toward the core and writes a fixed 4-bit entry-cause code into a status field. The core then reports that it has halted, and the block raises debug acknowledge. A separate CPU-done flag rises later, once the entry barrier has finished and the core's memory traffic from before the halt has drained. A software-writable bit can force acknowledge high at any time. A restart input starts the exit. When the core reports that it is running again, acknowledge and CPU-done drop. The core pipeline, the barrier itself and the other debug entry causes are outside this block and appear only as stub inputs.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: `perm_invasive` equals the `auth_dbg_en` value sampled at the previous clock edge.
- R2: `perm_noninv` equals the OR of `auth_dbg_en` and `auth_nid_en` sampled at the previous clock edge. With both enables at 0, both permission outputs are 0.
- R3: A `halt_req` seen while `perm_invasive` is 1 raises `halt_cmd` after the next edge. `halt_cmd` stays high until the edge at which `core_halted` is sampled high.
- R4: An accepted halt request writes the code 4'b0100 into `entry_method` at the same edge that raises `halt_cmd`. The field keeps this value after the exit.
- R5: A `halt_req` seen while `perm_invasive` is 0 is ignored. `halt_cmd` stays low and `entry_method` keeps its previous value.
- R6: `req_violation` is a one-cycle pulse that follows every cycle in which `halt_cmd` is high while both `halt_req` and `core_halted` are low.
- R7: `dbg_ack` rises after the edge that samples `core_halted` high while `halt_cmd` is high. It stays high through the wait for restart and the exit.
- R8: `dbg_ack` is high in any cycle in which `sw_ack_force` is 1, with no clock delay.
- R9: While halted, `cpu_done` rises after the first edge at which `mem_idle` is high and `barrier_done` is high now or was high earlier in the same halt.
- R10: A `restart_req` seen while halted starts the exit. After the edge that samples `core_running` high, `dbg_ack` (unless forced) and `cpu_done` are low.
- R11: During reset all outputs are 0 and `entry_method` is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auth_dbg_en | input | 1 | Authentication enable for invasive debug |
| auth_nid_en | input | 1 | Authentication enable for non-invasive debug |
| halt_req | input | 1 | External halt request |
| core_halted | input | 1 | Core stub: core has entered debug state |
| barrier_done | input | 1 | Core stub: entry barrier finished |
| mem_idle | input | 1 | Core stub: no memory access from before the halt is still in flight |
| restart_req | input | 1 | Request to leave debug state |
| core_running | input | 1 | Core stub: core is running again |
| sw_ack_force | input | 1 | Software acknowledge-force status bit |
| perm_invasive | output | 1 | Invasive debug permitted |
| perm_noninv | output | 1 | Non-invasive debug permitted |
| halt_cmd | output | 1 | Halt command to the core |
| dbg_ack | output | 1 | Debug acknowledge |
| cpu_done | output | 1 | Entry barrier done and memory drained |
| entry_method | output | 4 | Method-of-entry status field |
| req_violation | output | 1 | Halt request dropped before acknowledge |

## Verification
The bench builds the block with its default parameters. These are the registered permission stage, a 4-bit entry field and the entry code 4'b0100. With these values the one-cycle permission latency is visible at the ports, so the bench can show that a request arriving in the same cycle as the enable is refused. The default code width also lets the bench confirm that a refused request leaves the field unchanged. A behavioural reference model tracks the state across accepted, refused and dropped requests. It also covers barrier and drain reported in either order or together, and a forced acknowledge in every phase.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_REQ  = 2'd1,
      ST_HALT = 2'd2,
      ST_EXIT = 2'd3
   } dbg_state_e;
endpackage

// File: rtl/dbg_auth_gate.sv
module dbg_auth_gate #(
   parameter bit REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dbg_en,
   input  logic nid_en,
   output logic inv_ok,
   output logic nonv_ok
);
   logic inv_d, nonv_d;
   assign inv_d  = dbg_en;
   assign nonv_d = dbg_en | nid_en;

   generate
      if (REGISTERED) begin : g_reg
         logic inv_q, nonv_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               inv_q  <= 1'b0;
               nonv_q <= 1'b0;
            end else begin
               inv_q  <= inv_d;
               nonv_q <= nonv_d;
            end
         end
         assign inv_ok  = inv_q;
         assign nonv_ok = nonv_q;
      end else begin : g_comb
         assign inv_ok  = inv_d;
         assign nonv_ok = nonv_d;
      end
   endgenerate
endmodule

// File: rtl/dbg_entry_fsm.sv
module dbg_entry_fsm
   import dbg_halt_pkg::*;
#(
   parameter int METHOD_W  = 4,
   parameter int HALT_CODE = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                inv_ok,
   input  logic                halt_req,
   input  logic                core_halted,
   input  logic                restart_req,
   input  logic                core_running,
   output logic                halt_cmd,
   output logic                core_ack,
   output logic                arm,
   output logic                clear,
   output logic [METHOD_W-1:0] method,
   output logic                violation
);
   localparam logic [METHOD_W-1:0] CODE = HALT_CODE[METHOD_W-1:0];

   dbg_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN:  if (halt_req && inv_ok) state_d = ST_REQ;
         ST_REQ:  if (core_halted)        state_d = ST_HALT;
         ST_HALT: if (restart_req)        state_d = ST_EXIT;
         ST_EXIT: if (core_running)       state_d = ST_RUN;
         default:                         state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_RUN;
         method    <= '0;
         violation <= 1'b0;
      end else begin
         state_q   <= state_d;
         violation <= (state_q == ST_REQ) && !halt_req && !core_halted;
         if (state_q == ST_RUN && state_d == ST_REQ)
            method <= CODE;
      end
   end

   assign halt_cmd = (state_q == ST_REQ);
   assign core_ack = (state_q == ST_HALT) || (state_q == ST_EXIT);
   assign arm      = (state_q == ST_HALT);
   assign clear    = (state_q == ST_EXIT) && core_running;
endmodule

// File: rtl/dbg_done_track.sv
module dbg_done_track (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic clear,
   input  logic barrier_done,
   input  logic mem_idle,
   output logic cpu_done
);
   logic bar_seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bar_seen_q <= 1'b0;
         cpu_done   <= 1'b0;
      end else if (clear) begin
         bar_seen_q <= 1'b0;
         cpu_done   <= 1'b0;
      end else if (arm) begin
         if (barrier_done)
            bar_seen_q <= 1'b1;
         if ((bar_seen_q || barrier_done) && mem_idle)
            cpu_done <= 1'b1;
      end
   end
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl #(
   parameter bit AUTH_REGISTERED = 1'b1,
   parameter int METHOD_W        = 4,
   parameter int HALT_CODE       = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                auth_dbg_en,
   input  logic                auth_nid_en,
   input  logic                halt_req,
   input  logic                core_halted,
   input  logic                barrier_done,
   input  logic                mem_idle,
   input  logic                restart_req,
   input  logic                core_running,
   input  logic                sw_ack_force,
   output logic                perm_invasive,
   output logic                perm_noninv,
   output logic                halt_cmd,
   output logic                dbg_ack,
   output logic                cpu_done,
   output logic [METHOD_W-1:0] entry_method,
   output logic                req_violation
);
   generate
      if (METHOD_W < 1 || METHOD_W > 16) begin : g_bad_width
         $error("dbg_halt_ctrl: METHOD_W out of range");
      end
      if (HALT_CODE < 0 || HALT_CODE >= (1 << METHOD_W)) begin : g_bad_code
         $error("dbg_halt_ctrl: HALT_CODE does not fit METHOD_W");
      end
   endgenerate

   logic core_ack, arm, clear;

   dbg_auth_gate #(.REGISTERED(AUTH_REGISTERED)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .dbg_en  (auth_dbg_en),
      .nid_en  (auth_nid_en),
      .inv_ok  (perm_invasive),
      .nonv_ok (perm_noninv)
   );

   dbg_entry_fsm #(.METHOD_W(METHOD_W), .HALT_CODE(HALT_CODE)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .inv_ok       (perm_invasive),
      .halt_req     (halt_req),
      .core_halted  (core_halted),
      .restart_req  (restart_req),
      .core_running (core_running),
      .halt_cmd     (halt_cmd),
      .core_ack     (core_ack),
      .arm          (arm),
      .clear        (clear),
      .method       (entry_method),
      .violation    (req_violation)
   );

   dbg_done_track u_done (
      .clk          (clk),
      .rst_n        (rst_n),
      .arm          (arm),
      .clear        (clear),
      .barrier_done (barrier_done),
      .mem_idle     (mem_idle),
      .cpu_done     (cpu_done)
   );

   assign dbg_ack = core_ack | sw_ack_force;
endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
module dbg_halt_ctrl_chk #(
   parameter bit AUTH_REGISTERED = 1'b1,
   parameter int METHOD_W        = 4,
   parameter int HALT_CODE       = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                auth_dbg_en,
   input logic                auth_nid_en,
   input logic                halt_req,
   input logic                core_halted,
   input logic                barrier_done,
   input logic                mem_idle,
   input logic                restart_req,
   input logic                core_running,
   input logic                sw_ack_force,
   input logic                perm_invasive,
   input logic                perm_noninv,
   input logic                halt_cmd,
   input logic                dbg_ack,
   input logic                cpu_done,
   input logic [METHOD_W-1:0] entry_method,
   input logic                req_violation
);
   localparam logic [METHOD_W-1:0] CODE = HALT_CODE[METHOD_W-1:0];

   generate
      if (AUTH_REGISTERED) begin : g_reg_chk
         assert_inv_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
            auth_dbg_en |=> perm_invasive);
         assert_inv_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !auth_dbg_en |=> !perm_invasive);
      end
   endgenerate

   assert_inv_implies_noninv_R2: assert property (@(posedge clk) disable iff (!rst_n)
      perm_invasive |-> perm_noninv);

   assert_cmd_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_cmd && core_halted) |=> (!halt_cmd && dbg_ack));

   assert_method_on_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt_cmd) |-> (entry_method == CODE));

   assert_halt_needs_perm_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt_cmd) |-> $past(perm_invasive));

   assert_violation_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_violation |-> ($past(halt_cmd) && !$past(halt_req) && !$past(core_halted)));

   assert_force_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sw_ack_force |-> dbg_ack);

   assert_done_implies_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> (dbg_ack && !halt_cmd));

   assert_done_needs_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_done) |-> $past(mem_idle));

   logic unused_ok;
   assign unused_ok = &{1'b0, auth_nid_en, barrier_done, restart_req, core_running};
endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk #(
   .AUTH_REGISTERED(AUTH_REGISTERED),
   .METHOD_W       (METHOD_W),
   .HALT_CODE      (HALT_CODE)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .auth_dbg_en   (auth_dbg_en),
   .auth_nid_en   (auth_nid_en),
   .halt_req      (halt_req),
   .core_halted   (core_halted),
   .barrier_done  (barrier_done),
   .mem_idle      (mem_idle),
   .restart_req   (restart_req),
   .core_running  (core_running),
   .sw_ack_force  (sw_ack_force),
   .perm_invasive (perm_invasive),
   .perm_noninv   (perm_noninv),
   .halt_cmd      (halt_cmd),
   .dbg_ack       (dbg_ack),
   .cpu_done      (cpu_done),
   .entry_method  (entry_method),
   .req_violation (req_violation)
);

// File: tb/tb_dbg_halt_ctrl.sv
module tb_dbg_halt_ctrl;
   timeunit 1ns;
   timeprecision 100ps;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic auth_dbg_en = 0, auth_nid_en = 0, halt_req = 0, core_halted = 0;
   logic barrier_done = 0, mem_idle = 0, restart_req = 0, core_running = 0;
   logic sw_ack_force = 0;
   logic perm_invasive, perm_noninv, halt_cmd, dbg_ack, cpu_done, req_violation;
   logic [3:0] entry_method;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   dbg_halt_ctrl dut (
      .clk(clk), .rst_n(rst_n), .auth_dbg_en(auth_dbg_en), .auth_nid_en(auth_nid_en),
      .halt_req(halt_req), .core_halted(core_halted), .barrier_done(barrier_done),
      .mem_idle(mem_idle), .restart_req(restart_req), .core_running(core_running),
      .sw_ack_force(sw_ack_force), .perm_invasive(perm_invasive), .perm_noninv(perm_noninv),
      .halt_cmd(halt_cmd), .dbg_ack(dbg_ack), .cpu_done(cpu_done),
      .entry_method(entry_method), .req_violation(req_violation)
   );

   // Reference model: 0 run, 1 requesting, 2 halted, 3 exiting
   int       m_st;
   bit       m_inv, m_nonv, m_viol, m_bar, m_done;
   bit [3:0] m_method;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_inv = 0; m_nonv = 0; m_viol = 0;
         m_bar = 0; m_done = 0; m_method = 4'b0000;
      end else begin
         int nst;
         nst = m_st;
         m_viol = (m_st == 1) && !halt_req && !core_halted;
         case (m_st)
            0: if (halt_req && m_inv) begin nst = 1; m_method = 4'b0100; end
            1: if (core_halted) nst = 2;
            2: begin
               if ((m_bar || barrier_done) && mem_idle) m_done = 1;
               if (barrier_done) m_bar = 1;
               if (restart_req) nst = 3;
            end
            default: if (core_running) begin nst = 0; m_done = 0; m_bar = 0; end
         endcase
         m_st   = nst;
         m_inv  = auth_dbg_en;
         m_nonv = auth_dbg_en | auth_nid_en;
      end
   end

   task automatic check(string tag, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check("R1 perm_invasive", perm_invasive, m_inv);
         check("R2 perm_noninv", perm_noninv, m_nonv);
         check("R3/R5 halt_cmd", halt_cmd, m_st == 1);
         check("R4/R5 entry_method", entry_method, m_method);
         check("R6 req_violation", req_violation, m_viol);
         check("R7/R8/R10 dbg_ack", dbg_ack, (m_st >= 2) || sw_ack_force);
         check("R9/R10 cpu_done", cpu_done, m_done);
      end
   end

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      #(5ns * 20000);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      step(3);
      // R11 reset state
      check("R11 reset perm_invasive", perm_invasive, 0);
      check("R11 reset perm_noninv", perm_noninv, 0);
      check("R11 reset halt_cmd", halt_cmd, 0);
      check("R11 reset dbg_ack", dbg_ack, 0);
      check("R11 reset cpu_done", cpu_done, 0);
      check("R11 reset entry_method", entry_method, 0);
      check("R11 reset req_violation", req_violation, 0);
      rst_n = 1;
      step(2);
      // R2: both enables low, then observation only; R5: refused request
      auth_nid_en = 1;
      step(2);
      halt_req = 1;
      step(4);
      check("R5 refused request leaves field", entry_method, 0);
      halt_req = 0;
      // R1: request in same cycle as enable is refused
      auth_dbg_en = 1; halt_req = 1;
      step(1);
      halt_req = 0;
      step(2);
      // Normal entry with held request, barrier before drain
      halt_req = 1;
      step(3);
      check("R3 halt_cmd raised", halt_cmd, 1);
      check("R4 code written", entry_method, 4'b0100);
      core_halted = 1;
      step(1);
      core_halted = 0; halt_req = 0;
      check("R7 ack after halt", dbg_ack, 1);
      barrier_done = 1;
      step(1);
      barrier_done = 0;
      step(3);
      check("R9 no done before drain", cpu_done, 0);
      mem_idle = 1;
      step(2);
      check("R9 done after drain", cpu_done, 1);
      restart_req = 1;
      step(1);
      restart_req = 0;
      step(2);
      core_running = 1;
      step(1);
      core_running = 0; mem_idle = 0;
      check("R10 ack cleared", dbg_ack, 0);
      check("R10 done cleared", cpu_done, 0);
      // R8: forced acknowledge while running
      sw_ack_force = 1;
      step(2);
      check("R8 forced ack", dbg_ack, 1);
      sw_ack_force = 0;
      step(1);
      // R6: request dropped before acknowledge
      halt_req = 1;
      step(2);
      halt_req = 0;
      step(3);
      core_halted = 1;
      step(1);
      core_halted = 0;
      // barrier and drain together, force during halt
      sw_ack_force = 1;
      barrier_done = 1; mem_idle = 1;
      step(1);
      barrier_done = 0; mem_idle = 0;
      step(2);
      sw_ack_force = 0;
      // drain before barrier on a second halt after exit
      restart_req = 1;
      step(1);
      restart_req = 0; core_running = 1;
      step(1);
      core_running = 0;
      step(1);
      halt_req = 1;
      step(2);
      core_halted = 1;
      step(1);
      core_halted = 0; halt_req = 0; mem_idle = 1;
      step(3);
      barrier_done = 1;
      step(1);
      barrier_done = 0;
      step(2);
      restart_req = 1;
      step(1);
      restart_req = 0; core_running = 1; sw_ack_force = 1;
      step(1);
      core_running = 0;
      step(1);
      sw_ack_force = 0; mem_idle = 0;
      // R5: invasive revoked, request ignored, field kept
      auth_dbg_en = 0;
      step(2);
      halt_req = 1;
      step(4);
      check("R5 ignored halt_cmd", halt_cmd, 0);
      check("R4 field kept after exit", entry_method, 4'b0100);
      halt_req = 0;
      auth_nid_en = 0;
      step(3);
      finish_run();
   end
endmodule